// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Generator

This block produces the processor reset for a supply supervisor. Three things can assert the reset: the power-on event, a low-supply indication from an external comparator, and a watchdog that expires because the processor stopped toggling its bus-activity line. Each of these is followed by a single shared stretch period, so the supply and the oscillator can settle before code runs again. Both reset polarities are driven from one register.

All counting advances on a timebase tick enable input. The stretch lasts `HOLD_TICKS` ticks. The watchdog interval is chosen by a 2-bit select that comes from a nonvolatile control register. That select offers three preset intervals and a code that disables the watchdog. The asynchronous inputs pass through a synchroniser before they are used. The select is treated as quasi-static register state.

Top module: `sup_reset_gen`

## Requirements
- R1: While `por_n` is low, reset is asserted. After `por_n` rises, reset stays asserted for `HOLD_TICKS` (default 256) ticks plus synchroniser latency.
- R2: Reset is asserted within a few cycles of `supply_low_a` going high, and stays asserted for as long as it is high.
- R3: After `supply_low_a` returns low, reset remains asserted for `HOLD_TICKS` further ticks and then deasserts.
- R4: If any reset cause becomes active again during the stretch, the stretch restarts from zero.
- R5: With `wd_sel` = 2'b00, 2'b01 or 2'b10, reset is asserted once `WD_SHORT_TICKS` (1024), `WD_MID_TICKS` (4096) or `WD_LONG_TICKS` (16384) ticks pass without a kick.
- R6: With `wd_sel` = 2'b11 the watchdog never asserts reset.
- R7: A kick is a rising edge of the synchronised `kick_a`, and it restarts the interval. A level held high does not keep restarting it.
- R8: The watchdog counter is held clear while reset is asserted, so the interval is measured from reset release.
- R9: `rst_out` is high and `rst_out_n` is low exactly when reset is asserted.
- R10: The stretch and the watchdog advance only in cycles where `tick` is high.
- R11: A watchdog reset lasts `HOLD_TICKS` ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tick | input | 1 | Timebase tick enable for all counters |
| wd_sel | input | 2 | Watchdog interval select from the nonvolatile register |
| supply_low_a | input | 1 | Asynchronous low-supply indication, active high |
| kick_a | input | 1 | Asynchronous bus-activity line; a rising edge kicks the watchdog |
| rst_out_n | output | 1 | Reset output, active low |
| rst_out | output | 1 | Reset output, active high |

## Verification
The watchdog is driven in four ways:
- Steady kicking below the interval must never reset.
- Abandoned kicking must reset within a narrow window around the selected interval, which separates the three encodings from each other.
- A single rise held high shows that kicks are edge-detected rather than level-detected.
- The disabled code must stay silent over more than the longest interval.

For the supply cause, a long low pulse is followed by a measured stretch. A second pulse placed inside the stretch must restart the stretch. Running with the tick at half rate must double the stretch length, which separates tick-gated counting from free-running counting. Random kick gaps and selects then repeat the no-reset and timeout checks.

// File: rtl/sup_pkg.sv
package sup_pkg;
   typedef enum logic [1:0] {
      WD_SHORT = 2'b00,
      WD_MID   = 2'b01,
      WD_LONG  = 2'b10,
      WD_OFF   = 2'b11
   } wd_sel_e;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
   parameter int              W       = 2,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/sup_stretch.sv
module sup_stretch #(
   parameter int HOLD = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic cause,
   output logic active
);
   localparam int CW = (HOLD > 2) ? $clog2(HOLD) : 1;
   localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b1;
         cnt    <= '0;
      end else if (cause) begin
         active <= 1'b1;
         cnt    <= '0;
      end else if (active && tick) begin
         if (cnt == LAST) begin
            active <= 1'b0;
            cnt    <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   AST_CAUSE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      cause |=> (active && cnt == '0)); // R4
   AST_CLEAN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> ($past(cnt) == LAST && !$past(cause))); // R3
   AST_FREEZE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !cause) |=> $stable(cnt)); // R10
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
   import sup_pkg::*;
#(
   parameter int T_SHORT = 1024,
   parameter int T_MID   = 4096,
   parameter int T_LONG  = 16384
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rst_active,
   input  logic       kick_s,
   input  logic [1:0] sel,
   output logic       expire
);
   localparam int CW = $clog2(T_LONG);
   localparam logic [CW-1:0] LIM_S = CW'(T_SHORT - 1);
   localparam logic [CW-1:0] LIM_M = CW'(T_MID - 1);
   localparam logic [CW-1:0] LIM_L = CW'(T_LONG - 1);

   logic [CW-1:0] cnt, limit;
   logic          kick_d, kick_rise, off;

   assign kick_rise = kick_s & ~kick_d;
   assign off       = (wd_sel_e'(sel) == WD_OFF);

   always_comb begin
      unique case (wd_sel_e'(sel))
         WD_SHORT: limit = LIM_S;
         WD_MID:   limit = LIM_M;
         default:  limit = LIM_L;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         expire <= 1'b0;
         kick_d <= 1'b0;
      end else begin
         kick_d <= kick_s;
         expire <= 1'b0;
         if (rst_active || off || kick_rise) begin
            cnt <= '0;
         end else if (tick) begin
            if (cnt >= limit) begin
               expire <= 1'b1;
               cnt    <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   AST_HELD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      rst_active |=> (cnt == '0 && !expire)); // R8
   AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      off |=> !expire); // R6
   AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      kick_rise |=> (cnt == '0)); // R7
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
   parameter int HOLD_TICKS     = 256,
   parameter int WD_SHORT_TICKS = 1024,
   parameter int WD_MID_TICKS   = 4096,
   parameter int WD_LONG_TICKS  = 16384,
   parameter int SYNC_STAGES    = 2
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       tick,
   input  logic [1:0] wd_sel,
   input  logic       supply_low_a,
   input  logic       kick_a,
   output logic       rst_out_n,
   output logic       rst_out
);
   if (HOLD_TICKS < 2) begin : g_bad_hold
      $error("HOLD_TICKS must be at least 2");
   end
   if (!(WD_SHORT_TICKS >= 2 && WD_SHORT_TICKS < WD_MID_TICKS && WD_MID_TICKS < WD_LONG_TICKS))
   begin : g_bad_wd
      $error("watchdog intervals must be at least 2 and strictly increasing");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic       supply_low_s, kick_s, wd_expire, rst_q, cause;
   logic [1:0] sync_q;

   sup_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
      .clk   (clk),
      .rst_n (por_n),
      .d     ({supply_low_a, kick_a}),
      .q     (sync_q)
   );
   assign supply_low_s = sync_q[1];
   assign kick_s       = sync_q[0];

   sup_wdog #(.T_SHORT(WD_SHORT_TICKS), .T_MID(WD_MID_TICKS), .T_LONG(WD_LONG_TICKS)) u_wdog (
      .clk        (clk),
      .rst_n      (por_n),
      .tick       (tick),
      .rst_active (rst_q),
      .kick_s     (kick_s),
      .sel        (wd_sel),
      .expire     (wd_expire)
   );

   assign cause = supply_low_s | wd_expire;

   sup_stretch #(.HOLD(HOLD_TICKS)) u_stretch (
      .clk    (clk),
      .rst_n  (por_n),
      .tick   (tick),
      .cause  (cause),
      .active (rst_q)
   );

   assign rst_out   = rst_q;
   assign rst_out_n = ~rst_q;

   AST_EXPIRE_RESETS: assert property (@(posedge clk) disable iff (!por_n)
      wd_expire |=> rst_out); // R5
   AST_LOW_RESETS: assert property (@(posedge clk) disable iff (!por_n)
      supply_low_s |=> (rst_out && !rst_out_n)); // R2
endmodule

// File: tb/tb_sup_reset_gen.sv
`timescale 1ns/1ps
module tb_sup_reset_gen;
   localparam int HOLD = 256;

   logic       clk = 1'b0;
   logic       por_n = 1'b0, tick = 1'b1, tick_mode = 1'b0;
   logic [1:0] wd_sel = 2'b00;
   logic       supply_low_a = 1'b0, kick_a = 1'b0;
   logic       rst_out_n, rst_out;
   int         checks = 0, failures = 0;

   always #2.5 clk = ~clk;
   always @(negedge clk) tick <= tick_mode ? ~tick : 1'b1;

   sup_reset_gen dut (
      .clk(clk), .por_n(por_n), .tick(tick), .wd_sel(wd_sel),
      .supply_low_a(supply_low_a), .kick_a(kick_a),
      .rst_out_n(rst_out_n), .rst_out(rst_out)
   );

   function automatic int wd_limit(input logic [1:0] s);
      case (s)
         2'b00:   return 1024;
         2'b01:   return 4096;
         default: return 16384;
      endcase
   endfunction

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_level(input logic lvl, input int max, output int n);
      n = 0;
      while (rst_out !== lvl && n < max) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic check_rng(input string tag, input int act, input int lo, input int hi);
      checks++;
      if (act < lo || act > hi) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
      end
   endtask

   task automatic check_bit(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic kick();
      kick_a = 1'b1; step(4);
      kick_a = 1'b0; step(4);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int n, lim;
      void'($urandom(32'd1234));
      step(4);
      check_bit("R1 por reset rst_out", rst_out, 1'b1);
      check_bit("R9 por reset rst_out_n", rst_out_n, 1'b0);
      por_n = 1'b1;
      wait_level(1'b0, 2000, n);
      check_rng("R1 hold after power-up", n, HOLD, HOLD + 6);
      check_bit("R9 released rst_out_n", rst_out_n, 1'b1);

      // R8: no kicks, short interval measured from reset release
      wait_level(1'b1, 3000, n);
      check_rng("R8 R5 short interval from release", n, 1020, 1030);
      check_bit("R9 wd reset rst_out_n", rst_out_n, 1'b0);
      wait_level(1'b0, 2000, n);
      check_rng("R11 watchdog reset length", n, HOLD - 2, HOLD + 6);

      // R7: regular kicks on the middle interval
      wd_sel = 2'b01;
      for (int i = 0; i < 3; i++) begin
         kick();
         wait_level(1'b1, 3000, n);
         check_rng("R7 kicked no reset", n, 3000, 3000);
      end
      kick();
      wait_level(1'b1, 6000, n);
      check_rng("R5 mid interval after last kick", n, 4096 - 12, 4096 + 6);
      wait_level(1'b0, 2000, n);

      wd_sel = 2'b10;
      wait_level(1'b1, 20000, n);
      check_rng("R5 long interval", n, 16380, 16390);
      wait_level(1'b0, 2000, n);

      wd_sel = 2'b11;
      wait_level(1'b1, 20000, n);
      check_rng("R6 disabled never resets", n, 20000, 20000);

      // R2 / R3: supply low
      supply_low_a = 1'b1;
      wait_level(1'b1, 50, n);
      check_rng("R2 low asserts reset", n, 1, 4);
      step(500);
      check_bit("R2 reset held while low", rst_out, 1'b1);
      supply_low_a = 1'b0;
      wait_level(1'b0, 2000, n);
      check_rng("R3 hold after recovery", n, HOLD, HOLD + 6);

      // R4: retrigger during stretch
      supply_low_a = 1'b1; step(20); supply_low_a = 1'b0;
      step(100);
      check_bit("R4 still in stretch", rst_out, 1'b1);
      supply_low_a = 1'b1; step(10); supply_low_a = 1'b0;
      wait_level(1'b0, 2000, n);
      check_rng("R4 stretch restarted", n, HOLD, HOLD + 6);

      // R10: half-rate tick doubles the stretch
      tick_mode = 1'b1;
      supply_low_a = 1'b1; step(20); supply_low_a = 1'b0;
      wait_level(1'b0, 3000, n);
      check_rng("R10 half-rate stretch", n, 2 * HOLD - 2, 2 * HOLD + 12);
      tick_mode = 1'b0;
      step(4);

      // R7: level held high is one kick only
      wd_sel = 2'b00;
      kick_a = 1'b1;
      wait_level(1'b1, 3000, n);
      check_rng("R7 held level still times out", n, 1018, 1032);
      wait_level(1'b0, 2000, n);
      kick_a = 1'b0;
      step(4);

      // random kick gaps and selects
      for (int it = 0; it < 6; it++) begin
         int k;
         wd_sel = 2'($urandom % 2);
         lim = wd_limit(wd_sel);
         kick();
         k = 1 + int'($urandom % 3);
         for (int j = 0; j < k; j++) begin
            int gap;
            gap = int'($urandom % (lim / 2));
            wait_level(1'b1, gap, n);
            check_rng("R7 random kicks no reset", n, gap, gap);
            kick();
         end
         wait_level(1'b1, 20000, n);
         check_rng("R5 random timeout", n, lim - 12, lim + 6);
         wait_level(1'b0, 2000, n);
         step(int'($urandom % 8));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule